// File: doc/BRIEF.md
# Packed-Pixel Bitmap Memory Port

This block lets a master address a byte-wide RAM one pixel at a time, even though the RAM stores pixels packed two or four to a byte. The master presents a pixel index, a read or write strobe, write data and a format select. In 4-bit format each byte holds two pixels. In 2-bit format each byte holds four pixels. The block turns each pixel access into the right byte address and bit field.

A read fetches the byte that holds the pixel. It returns that pixel's field in the low bits of an 8-bit result, with the upper bits cleared, and marks the result with a one-cycle valid pulse. A write is a read-modify-write. The block first reads the byte. In the next cycle it writes the byte back with only the selected field replaced. While either operation is in flight the block raises `busy` and accepts no new request. A master whose request is not accepted must present it again later.

The RAM is synchronous. Read data appears on `ram_rdata` in the cycle after `ram_re` is asserted with an address. The RAM array itself and any sharing of it with other masters sit outside this block.

Top module: `pixmem_port`

## Requirements
- R1: In 4-bit format (`fmt_2bpp`=0), the byte address is the pixel index shifted right by 1. Index bit 0 selects the pixel: 0 selects byte bits [3:0] and 1 selects bits [7:4].
- R2: In 2-bit format (`fmt_2bpp`=1), the byte address is the pixel index shifted right by 2. Index bits [1:0] select the pixel: 0 selects byte bits [1:0], 1 selects [3:2], 2 selects [5:4] and 3 selects [7:6].
- R3: Read data carries the selected field in its low bits (4 or 2 bits wide), and every bit above the field is zero.
- R4: A write replaces only the selected field, with the low 4 or 2 bits of `req_wdata`. Every other bit of the byte keeps its old value, and the upper bits of `req_wdata` have no effect.
- R5: The byte address is truncated to `RAM_AW` bits, so index bits above the RAM size have no effect on which byte is accessed.
- R6: A write is accepted in the cycle that `ram_re` is high with the byte address. In the next cycle the block asserts `ram_we` with the same address and the merged byte, and `busy` is high throughout that cycle. After that cycle `busy` returns low.
- R7: A read that is accepted at clock edge k raises `rd_valid` for exactly one cycle after edge k+1, with `rd_data` valid alongside it. `busy` is high in the cycle between.
- R8: While `busy` is high, request strobes are ignored. No RAM access is started, the request is not queued, and no later `rd_valid` results from it.
- R9: If `req_rd` and `req_wr` are both high when the block is idle, the request is treated as a write.
- R10: After reset, `busy`, `rd_valid`, `ram_re` and `ram_we` are low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_rd | input | 1 | Pixel read request |
| req_wr | input | 1 | Pixel write request |
| req_idx | input | IDX_W (20) | Pixel index |
| req_wdata | input | 8 | Pixel write data; only the low 4 or 2 bits are used |
| fmt_2bpp | input | 1 | Format select: 0 = 4 bits per pixel, 1 = 2 bits per pixel |
| busy | output | 1 | Operation in flight; requests are ignored |
| rd_valid | output | 1 | One-cycle pulse marking read data |
| rd_data | output | 8 | Zero-extended pixel value |
| ram_addr | output | RAM_AW (10) | RAM byte address |
| ram_re | output | 1 | RAM read enable |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data (merged byte) |
| ram_rdata | input | 8 | RAM read data, valid one cycle after `ram_re` |

## Verification
The bench writes to every nibble and every pair slot, in bytes preloaded with random contents. A merge that used the wrong mask, or the wrong shift, would corrupt neighbouring pixels, and the RAM contents would then differ from the bench's shadow copy. Indexes carry random bits above the RAM size, and write data carries random upper bits. A design that did not truncate the address would reach the wrong byte, and one that did not mask the data would spill bits into other pixels. Some requests arrive while the block is busy, and some assert both strobes at once. A design that queued the early request, or treated the double strobe as a read, would show an extra RAM read, a stray `rd_valid`, or an unchanged byte.

// File: rtl/pixmem_pkg.sv
package pixmem_pkg;
    localparam int BYTE_W = 8;
    localparam int POS_W  = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_RET = 2'd1,
        ST_MERGE  = 2'd2
    } pm_state_e;

    // Width mask of one pixel field, before it is shifted into position.
    function automatic logic [BYTE_W-1:0] field_mask(input logic fmt2);
        return fmt2 ? 8'h03 : 8'h0F;
    endfunction
endpackage

// File: rtl/pixmem_locate.sv
module pixmem_locate
    import pixmem_pkg::*;
#(
    parameter int IDX_W  = 20,
    parameter int RAM_AW = 10
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic              fmt2,
    output logic [RAM_AW-1:0] byte_addr,
    output logic [POS_W-1:0]  bit_pos
);
    localparam int EXT_W = (RAM_AW > IDX_W) ? RAM_AW : IDX_W;

    logic [IDX_W-1:0] half_idx;
    logic [IDX_W-1:0] quarter_idx;
    logic [EXT_W-1:0] sel_ext;

    assign half_idx    = idx >> 1;
    assign quarter_idx = idx >> 2;
    assign sel_ext     = EXT_W'(fmt2 ? quarter_idx : half_idx);
    assign byte_addr   = sel_ext[RAM_AW-1:0];

    // Bit offset of the field inside the byte.
    assign bit_pos = fmt2 ? {idx[1:0], 1'b0} : {idx[0], 2'b00};
endmodule

// File: rtl/pixmem_extract.sv
module pixmem_extract
    import pixmem_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              fmt2,
    input  logic [POS_W-1:0]  bit_pos,
    output logic [BYTE_W-1:0] pix_out
);
    logic [BYTE_W-1:0] shifted;
    assign shifted = byte_in >> bit_pos;
    assign pix_out = shifted & field_mask(fmt2);
endmodule

// File: rtl/pixmem_merge.sv
module pixmem_merge
    import pixmem_pkg::*;
(
    input  logic [BYTE_W-1:0] old_byte,
    input  logic [BYTE_W-1:0] new_pix,
    input  logic              fmt2,
    input  logic [POS_W-1:0]  bit_pos,
    output logic [BYTE_W-1:0] merged
);
    logic [BYTE_W-1:0] keep_mask;
    logic [BYTE_W-1:0] ins_bits;

    assign keep_mask = ~(field_mask(fmt2) << bit_pos);
    assign ins_bits  = (new_pix & field_mask(fmt2)) << bit_pos;
    assign merged    = (old_byte & keep_mask) | ins_bits;
endmodule

// File: rtl/pixmem_port.sv
module pixmem_port
    import pixmem_pkg::*;
#(
    parameter int IDX_W  = 20,
    parameter int RAM_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [BYTE_W-1:0] req_wdata,
    input  logic              fmt_2bpp,
    output logic              busy,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_re,
    output logic              ram_we,
    output logic [BYTE_W-1:0] ram_wdata,
    input  logic [BYTE_W-1:0] ram_rdata
);
    typedef struct packed {
        pm_state_e         st;
        logic [RAM_AW-1:0] addr;
        logic [POS_W-1:0]  pos;
        logic              fmt2;
        logic [BYTE_W-1:0] wdata;
        logic              rd_valid;
        logic [BYTE_W-1:0] rd_data;
    } regs_t;

    regs_t r_d, r_q;

    logic [RAM_AW-1:0] loc_addr;
    logic [POS_W-1:0]  loc_pos;
    logic [BYTE_W-1:0] ext_pix;
    logic [BYTE_W-1:0] merged_byte;

    pixmem_locate #(.IDX_W(IDX_W), .RAM_AW(RAM_AW)) u_locate (
        .idx       (req_idx),
        .fmt2      (fmt_2bpp),
        .byte_addr (loc_addr),
        .bit_pos   (loc_pos)
    );

    pixmem_extract u_extract (
        .byte_in (ram_rdata),
        .fmt2    (r_q.fmt2),
        .bit_pos (r_q.pos),
        .pix_out (ext_pix)
    );

    pixmem_merge u_merge (
        .old_byte (ram_rdata),
        .new_pix  (r_q.wdata),
        .fmt2     (r_q.fmt2),
        .bit_pos  (r_q.pos),
        .merged   (merged_byte)
    );

    always_comb begin
        r_d          = r_q;
        r_d.rd_valid = 1'b0;
        ram_re       = 1'b0;
        ram_we       = 1'b0;
        ram_addr     = loc_addr;
        ram_wdata    = merged_byte;
        case (r_q.st)
            ST_IDLE: begin
                if (req_wr || req_rd) begin
                    ram_re    = 1'b1;
                    r_d.addr  = loc_addr;
                    r_d.pos   = loc_pos;
                    r_d.fmt2  = fmt_2bpp;
                    r_d.wdata = req_wdata;
                    r_d.st    = req_wr ? ST_MERGE : ST_RD_RET;
                end
            end
            ST_RD_RET: begin
                ram_addr     = r_q.addr;
                r_d.rd_valid = 1'b1;
                r_d.rd_data  = ext_pix;
                r_d.st       = ST_IDLE;
            end
            ST_MERGE: begin
                ram_addr = r_q.addr;
                ram_we   = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign rd_valid = r_q.rd_valid;
    assign rd_data  = r_q.rd_data;

    AST_WE_FOLLOWS_RE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ($past(ram_re) && !ram_re)); // R6
    AST_WE_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_addr == $past(ram_addr))); // R6
    AST_MERGE_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (((ram_wdata ^ ram_rdata) & ~(field_mask(r_q.fmt2) << r_q.pos)) == '0)); // R4
    AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(busy) && !$past(ram_we))); // R7
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R7
    AST_RD_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[BYTE_W-1:4] == '0)); // R3
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ram_re); // R8
    AST_BOTH_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_rd && req_wr) |=> ram_we); // R9
endmodule

// File: tb/pixmem_port_tb.sv
`timescale 1ns/1ps
module pixmem_port_tb;
    localparam int IDX_W  = 20;
    localparam int AW     = 10;
    localparam int DEPTH  = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_rd = 1'b0, req_wr = 1'b0, fmt_2bpp = 1'b0;
    logic [IDX_W-1:0] req_idx = '0;
    logic [7:0] req_wdata = '0;
    logic busy, rd_valid, ram_re, ram_we;
    logic [7:0] rd_data, ram_wdata;
    logic [7:0] ram_rdata = '0;
    logic [AW-1:0] ram_addr;

    logic [7:0] mem    [DEPTH];
    logic [7:0] shadow [DEPTH];

    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pixmem_port #(.IDX_W(IDX_W), .RAM_AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
        .req_idx(req_idx), .req_wdata(req_wdata), .fmt_2bpp(fmt_2bpp),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .ram_addr(ram_addr), .ram_re(ram_re), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        if (ram_re) ram_rdata <= mem[ram_addr];
    end

    function automatic logic [AW-1:0] e_addr(input logic [IDX_W-1:0] idx, input logic f);
        return f ? idx[AW+1:2] : idx[AW:1];
    endfunction

    function automatic logic [7:0] e_field(input logic [7:0] b, input logic [IDX_W-1:0] idx, input logic f);
        if (!f) return idx[0] ? {4'h0, b[7:4]} : {4'h0, b[3:0]};
        case (idx[1:0])
            2'd0: return {6'd0, b[1:0]};
            2'd1: return {6'd0, b[3:2]};
            2'd2: return {6'd0, b[5:4]};
            default: return {6'd0, b[7:6]};
        endcase
    endfunction

    function automatic logic [7:0] e_merge(input logic [7:0] b, input logic [IDX_W-1:0] idx,
                                           input logic f, input logic [7:0] d);
        logic [7:0] r;
        r = b;
        if (!f) begin
            if (idx[0]) r[7:4] = d[3:0]; else r[3:0] = d[3:0];
        end else begin
            case (idx[1:0])
                2'd0: r[1:0] = d[1:0];
                2'd1: r[3:2] = d[1:0];
                2'd2: r[5:4] = d[1:0];
                default: r[7:6] = d[1:0];
            endcase
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_read(input logic [IDX_W-1:0] idx, input logic f);
        logic [AW-1:0] a;
        logic [7:0] ex;
        a  = e_addr(idx, f);
        ex = e_field(shadow[a], idx, f);
        @(negedge clk);
        req_rd = 1'b1; req_idx = idx; fmt_2bpp = f;
        #1;
        chk(ram_re == 1'b1, "R7 read strobe", 32'(ram_re), 1);
        chk(ram_addr == a, f ? "R2/R5 read addr" : "R1/R5 read addr", 32'(ram_addr), 32'(a));
        @(negedge clk);
        req_rd = 1'b0; req_idx = $urandom;
        #1;
        chk(busy && !rd_valid, "R7 busy gap", {busy, rd_valid}, 2'b10);
        @(negedge clk);
        #1;
        chk(rd_valid == 1'b1, "R7 valid pulse", 32'(rd_valid), 1);
        chk(rd_data == ex, f ? "R2/R3 read data" : "R1/R3 read data", 32'(rd_data), 32'(ex));
        @(negedge clk);
        #1;
        chk(rd_valid == 1'b0, "R7 single pulse", 32'(rd_valid), 0);
    endtask

    task automatic do_write(input logic [IDX_W-1:0] idx, input logic f, input logic [7:0] d,
                            input bit both, input bit intrude);
        logic [AW-1:0] a;
        logic [7:0] nb;
        a  = e_addr(idx, f);
        nb = e_merge(shadow[a], idx, f, d);
        @(negedge clk);
        req_wr = 1'b1; req_rd = both; req_idx = idx; fmt_2bpp = f; req_wdata = d;
        #1;
        chk(ram_re && ram_addr == a, "R6/R5 write fetch addr", 32'(ram_addr), 32'(a));
        @(negedge clk);
        req_wr = 1'b0; req_rd = intrude; req_idx = $urandom; req_wdata = $urandom;
        #1;
        chk(busy && ram_we, both ? "R9 both strobes write" : "R6 merge cycle", {busy, ram_we}, 2'b11);
        chk(ram_addr == a, "R6 merge addr", 32'(ram_addr), 32'(a));
        chk(ram_wdata == nb, f ? "R2/R4 merged byte" : "R1/R4 merged byte", 32'(ram_wdata), 32'(nb));
        if (intrude) chk(!ram_re, "R8 no fetch while busy", 32'(ram_re), 0);
        shadow[a] = nb;
        @(negedge clk);
        req_rd = 1'b0;
        #1;
        chk(!busy, "R6 busy released", 32'(busy), 0);
        chk(mem[a] == nb, "R4 RAM content", 32'(mem[a]), 32'(nb));
        if (intrude || both) begin
            @(negedge clk);
            #1;
            chk(!rd_valid && !busy, "R8/R9 no stray read", {rd_valid, busy}, 2'b00);
        end
    endtask

    initial begin
        void'($urandom(32'd20240517));
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = 8'($urandom);
            shadow[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !rd_valid && !ram_re && !ram_we, "R10 reset outputs",
            {busy, rd_valid, ram_re, ram_we}, 0);
        chk(rd_data == 8'h00, "R10 reset rd_data", 32'(rd_data), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed: every field position in each format, with high index bits set.
        mem[5] = 8'hA5; shadow[5] = 8'hA5;
        do_read(20'hF000A, 1'b0);
        do_read(20'h3000B, 1'b0);
        for (int k = 0; k < 4; k++) do_read(20'hAB014 | 20'(k), 1'b1);
        do_write(20'h0000A, 1'b0, 8'hF3, 1'b0, 1'b0);
        do_write(20'hFFC0B, 1'b0, 8'h7C, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) do_write(20'h50014 | 20'(k), 1'b1, 8'hFC | 8'(k), 1'b0, 1'b0);
        chk(mem[5] == shadow[5], "R2/R4 all pairs", 32'(mem[5]), 32'(shadow[5]));
        do_write(20'h00033, 1'b1, 8'h02, 1'b1, 1'b0);
        do_write(20'h00100, 1'b0, 8'h09, 1'b0, 1'b1);

        for (int n = 0; n < 400; n++) begin
            logic [IDX_W-1:0] ix;
            logic f;
            ix = IDX_W'($urandom);
            f  = 1'($urandom);
            case ($urandom % 4)
                0, 1: do_read(ix, f);
                2: do_write(ix, f, 8'($urandom), 1'b0, 1'($urandom));
                default: do_write(ix, f, 8'($urandom), 1'($urandom), 1'b0);
            endcase
        end

        for (int i = 0; i < DEPTH; i++) begin
            if (mem[i] != shadow[i]) chk(1'b0, "R4 final RAM image", 32'(mem[i]), 32'(shadow[i]));
        end
        tests++;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule